// File: doc/BRIEF.md
# Rate-Compatible LDPC Parity Puncturing Selector

This block sits behind a systematic LDPC encoder whose codeword holds K information bits followed by M parity bits. Given a requested transmit length, it produces the sequence of codeword bit indices to send, one index per handshake beat. All information bits are always sent first. The parity bits that survive puncturing follow in a fixed, nested order, so every shorter transmission is a prefix of every longer one. That nesting lets an incremental-redundancy retransmission continue where the previous one stopped.

The order of the first half of the parity (H = M/2 bits) is set by a permutation. Each first-half bit goes to one of eight bins, and the bins are read out in bit-reversed order. The second half of the parity follows in natural order. When the requested length is longer than the whole codeword, the sequence wraps to index 0 and repeats the codeword cyclically. At each start the block first spends H cycles writing the permuted first-half indices into a small RAM. It then streams the result.

Top module: `rcp_puncture_sel`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_last` and `busy` are 0.
- R2: `start` is accepted only when `busy` is 0. A `start` pulse during a run, even with different length inputs, leaves that run's index stream unchanged.
- R3: Output beats 0..K-1 carry the indices 0..K-1 in increasing order.
- R4: The first-half parity position t = p*z + q (0 <= q < z, 0 <= t < H) goes to bin t mod 8 and carries the parity offset p*z + ((p+q) mod z). Within a bin, entries keep increasing t.
- R5: The bins are read out in the order 0,4,2,6,1,5,3,7. Each entry is emitted as the codeword index K + offset.
- R6: For a parity count i = tx_len - K with i <= H, exactly the first i entries of the bin readout follow the information bits. When i = 0, only the information bits are sent.
- R7: For H < i <= M, all H bin entries are sent, followed by indices K+H, K+H+1, ... in order until i parity bits have been sent.
- R8: For tx_len > K+M, beat n carries the entry at position n mod (K+M) of the full-codeword sequence (cyclic repetition).
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_idx` and `out_last` hold their values.
- R10: Exactly tx_len beats are delivered. `out_last` is 1 only on the final beat. After that beat is accepted, `busy` and `out_valid` are 0.
- R11: No beat is offered while the first-half permutation is being written. The first beat appears more than H cycles after `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run using the length inputs |
| k_len | input | IW | Number of information bits K (at least 1) |
| m_len | input | IW | Number of parity bits M (even, M/2 a multiple of z) |
| z_len | input | IW | Lifting factor z |
| tx_len | input | TX_W | Total number of bits to transmit (at least 1) |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | `out_idx` holds a valid index |
| out_idx | output | IW | Codeword bit index to transmit |
| out_last | output | 1 | Marks the final beat of the run |
| busy | output | 1 | High from an accepted start until the final beat is taken |

## Verification
The hardest case to reach from the ports is the boundary where the stream crosses from the information bits into the RAM-backed bin readout. This happens while the downstream stalls, because the RAM read for the next index has to be issued in the same cycle the current one is accepted. Random `out_ready` patterns are therefore combined with small lifting factors (3, 4, 5). With those factors, bins are unequal in size and some hold a single entry. The wrap from the last parity index back to index 0 falls under the same stalls. One run also pulses `start` with different lengths partway through, to show that a run in progress cannot be disturbed.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int BINS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_EMIT
  } rcp_state_e;
endpackage

// File: rtl/rcp_bin_offsets.sv
// Start address of each bin inside the readout-ordered RAM image.
module rcp_bin_offsets #(
  parameter int IW = 14
) (
  input  logic [IW-1:0] half_len,
  output logic [IW-1:0] bin_base [rcp_pkg::BINS]
);
  import rcp_pkg::*;

  logic [IW-1:0] bin_size   [BINS];
  logic [IW-1:0] slot_start [BINS];

  // number of positions t < half_len with t mod 8 == g
  for (genvar g = 0; g < BINS; g++) begin : g_size
    assign bin_size[g] = (half_len > IW'(g))
                       ? (((half_len - IW'(g) - IW'(1)) >> 3) + IW'(1))
                       : '0;
  end

  // readout slot s serves bin bitrev3(s): 0,4,2,6,1,5,3,7
  for (genvar s = 0; s < BINS; s++) begin : g_slot
    localparam int BR = ((s & 1) << 2) | (s & 2) | ((s >> 2) & 1);
    localparam int PS = s - 1;
    localparam int BRP = ((PS & 1) << 2) | (PS & 2) | ((PS >> 2) & 1);
    if (s == 0) begin : g_first
      assign slot_start[s] = '0;
    end else begin : g_next
      assign slot_start[s] = slot_start[s-1] + bin_size[BRP];
    end
    assign bin_base[BR] = slot_start[s];
  end
endmodule

// File: rtl/rcp_fill_gen.sv
// Walks the first-half parity positions and produces RAM writes.
module rcp_fill_gen #(
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [IW-1:0] z_len,
  input  logic [IW-1:0] half_len,
  input  logic [IW-1:0] bin_base [rcp_pkg::BINS],
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [IW-1:0] wdata,
  output logic          fill_done
);
  logic          active;
  logic [IW-1:0] t_pos;     // p*z + q
  logic [IW-1:0] q_cnt;     // position inside block
  logic [IW-1:0] pz_base;   // p*z
  logic [IW-1:0] p_mod;     // p mod z
  logic [IW-1:0] rot;       // (p+q) mod z
  logic [IW-1:0] p_mod_nxt;

  assign p_mod_nxt = (p_mod == z_len - IW'(1)) ? '0 : p_mod + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      t_pos   <= '0;
      q_cnt   <= '0;
      pz_base <= '0;
      p_mod   <= '0;
      rot     <= '0;
    end else if (go) begin
      active  <= 1'b1;
      t_pos   <= '0;
      q_cnt   <= '0;
      pz_base <= '0;
      p_mod   <= '0;
      rot     <= '0;
    end else if (active) begin
      if (t_pos == half_len - IW'(1)) active <= 1'b0;
      t_pos <= t_pos + IW'(1);
      if (q_cnt == z_len - IW'(1)) begin
        q_cnt   <= '0;
        pz_base <= pz_base + z_len;
        p_mod   <= p_mod_nxt;
        rot     <= p_mod_nxt;
      end else begin
        q_cnt <= q_cnt + IW'(1);
        rot   <= (rot == z_len - IW'(1)) ? '0 : rot + IW'(1);
      end
    end
  end

  assign we        = active;
  assign waddr     = bin_base[t_pos[2:0]] + (t_pos >> 3);
  assign wdata     = pz_base + rot;
  assign fill_done = active && (t_pos == half_len - IW'(1));

  // R4: writes stay inside the first half, rotation stays inside the block
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (t_pos < half_len) && (rot < z_len) && (waddr < half_len));
endmodule

// File: rtl/rcp_index_ram.sv
// Simple dual-port RAM, synchronous read, inferable as block RAM.
module rcp_index_ram #(
  parameter int IW    = 14,
  parameter int DEPTH = 2400
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rcp_puncture_sel.sv
module rcp_puncture_sel #(
  parameter int CW_MAX   = 14400,
  parameter int HALF_MAX = 2400,
  parameter int TX_W     = 16,
  localparam int IW      = $clog2(CW_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IW-1:0]   k_len,
  input  logic [IW-1:0]   m_len,
  input  logic [IW-1:0]   z_len,
  input  logic [TX_W-1:0] tx_len,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [IW-1:0]   out_idx,
  output logic            out_last,
  output logic            busy
);
  import rcp_pkg::*;

  rcp_state_e      state;
  logic [IW-1:0]   k_r, z_r, h_r, cw_r, cur;
  logic [TX_W-1:0] tx_r, sent;

  logic [IW-1:0]   bin_base [BINS];
  logic            we, fill_done;
  logic [IW-1:0]   waddr, wdata, raddr, rdata;
  logic [IW-1:0]   cur_nxt, rd_pos, src;
  logic            load, accept_start;

  assign accept_start = start && (state == ST_IDLE);
  assign load    = (state == ST_EMIT) && (!out_valid || out_ready) && (sent != tx_r);
  assign cur_nxt = (cur == cw_r - IW'(1)) ? '0 : cur + IW'(1);
  // read ahead so the RAM word for the next beat is ready when it is loaded
  assign rd_pos  = load ? cur_nxt : cur;
  assign raddr   = rd_pos - k_r;

  always_comb begin
    if (cur < k_r)             src = cur;
    else if (cur < k_r + h_r)  src = k_r + rdata;
    else                       src = cur;
  end

  rcp_bin_offsets #(.IW(IW)) u_offsets (
    .half_len (h_r),
    .bin_base (bin_base)
  );

  rcp_fill_gen #(.IW(IW)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .go        (accept_start),
    .z_len     (z_r),
    .half_len  (h_r),
    .bin_base  (bin_base),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .fill_done (fill_done)
  );

  rcp_index_ram #(.IW(IW), .DEPTH(HALF_MAX)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_idx   <= '0;
      k_r       <= '0;
      z_r       <= '0;
      h_r       <= '0;
      cw_r      <= '0;
      tx_r      <= '0;
      cur       <= '0;
      sent      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            k_r   <= k_len;
            z_r   <= z_len;
            h_r   <= m_len >> 1;
            cw_r  <= k_len + m_len;
            tx_r  <= tx_len;
            cur   <= '0;
            sent  <= '0;
            busy  <= 1'b1;
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_done) state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (load) begin
            out_valid <= 1'b1;
            out_idx   <= src;
            out_last  <= (sent == tx_r - TX_W'(1));
            sent      <= sent + TX_W'(1);
            cur       <= cur_nxt;
          end else if (!out_valid || out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled beat is held
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_last));

  // R11: nothing offered while the permutation is written
  p_fill_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> !out_valid);

  // R2: run parameters do not move while busy
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cw_r) && $stable(tx_r) && $stable(h_r));

  // R10: taking the last beat ends the run
  p_last_idle_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !busy && !out_valid);

  // R3: every index lies inside the codeword
  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_idx < cw_r);
endmodule

// File: tb/rcp_puncture_sel_tb.sv
module rcp_puncture_sel_tb;
  localparam int IW    = 14;
  localparam int TX_W  = 16;
  localparam int LIMIT = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [IW-1:0]   k_len = '0, m_len = '0, z_len = '0;
  logic [TX_W-1:0] tx_len = '0;
  logic            out_ready = 1'b0;
  logic            out_valid, out_last, busy;
  logic [IW-1:0]   out_idx;

  int errors = 0;
  int checks = 0;
  logic [7:0] lf = 8'hA5;

  always #5 clk = ~clk;

  rcp_puncture_sel u_dut (
    .clk(clk), .rst(rst), .start(start),
    .k_len(k_len), .m_len(m_len), .z_len(z_len), .tx_len(tx_len),
    .out_ready(out_ready), .out_valid(out_valid), .out_idx(out_idx),
    .out_last(out_last), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int k, input int m, input int z, input int tx,
                          input int mode, input int stray_at, input string tag);
    int seq[$];
    int order[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    int h = m / 2;
    int cw = k + m;
    int n = 0;
    int cnt = 0;
    int first = -1;
    // reference codeword order: info, bins in bit-reversed order, second half
    for (int a = 0; a < k; a++) seq.push_back(a);
    for (int b = 0; b < 8; b++)
      for (int t = order[b]; t < h; t += 8) begin
        int p = t / z;
        int q = t % z;
        seq.push_back(k + p * z + ((p + q) % z));
      end
    for (int r = h; r < m; r++) seq.push_back(k + r);

    @(negedge clk);
    k_len = IW'(k); m_len = IW'(m); z_len = IW'(z); tx_len = TX_W'(tx);
    start = 1'b1;
    while (n < tx && cnt < LIMIT) begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (stray_at >= 0 && n == stray_at && cnt > 1) begin
        start = 1'b1;            // R2: ignored while busy
        k_len = IW'(3); m_len = IW'(8); z_len = IW'(2); tx_len = TX_W'(5);
        stray_at = -1;
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = (mode == 0) ? 1'b1 : (lf[0] | lf[2]);
      if (out_valid && first < 0) first = cnt;
      if (out_valid && out_ready) begin
        int pos = n % cw;
        string t2;
        if (n >= cw)          t2 = "R8";
        else if (pos < k)     t2 = "R3";
        else if (pos < k + h) t2 = "R4 R5";
        else                  t2 = "R7";
        check(int'(out_idx) == seq[pos], t2, int'(out_idx), seq[pos]);
        check(out_last == (n == tx - 1), "R10 last", int'(out_last), int'(n == tx - 1));
        n++;
      end
    end
    if (cnt >= LIMIT) check(1'b0, "watchdog", cnt, LIMIT);
    start = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !out_valid, "R10 idle", int'(busy), 0);
    check(n == tx, tag, n, tx);
    check(first > h, "R11", first, h + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !busy && !out_last, "R1 in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !busy && !out_last, "R1 after reset", int'(busy), 0);

    run_case(24, 24, 4, 24 + 5,  0, -1, "R6 below half");
    run_case(24, 24, 4, 24 + 12, 1, -1, "R6 at half");
    run_case(24, 24, 4, 24 + 20, 1, -1, "R7 above half");
    run_case(7,  18, 3, 7 + 18 + 40, 1, -1, "R8 repeat");
    run_case(16, 32, 8, 16, 0, -1, "R6 no parity");
    run_case(48, 48, 12, 48 + 30, 1, 3, "R2 stray start");
    run_case(10, 30, 5, 2 * 40 + 3, 1, -1, "R8 double wrap");
    run_case(5,  64, 4, 5 + 64, 0, -1, "R7 full codeword");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule